// File: doc/BRIEF.md
# Clock-Domain Shutdown and Restart Sequencer

This controller sits in an always-on clock domain beside a single-transaction register crossing. It takes one target domain out of service and later brings it back, always in a safe order. The target is either the register-slave side or the master side of the crossing. For the slave side, the sequencer first raises a bypass so that master requests complete as no-ops. It then waits until the crossing reports that no transaction is in flight. Next it asserts the domain reset, holds that reset for a minimum number of cycles, and can then stop the domain clock.

Restart runs the same steps in reverse. The clock is enabled first. Reset is released after the same hold count. For the slave side, bypass is dropped last. A master-side sequence has no bypass step.

The sequencer drives only bypass, reset and clock-enable. It has no output that could remove supply from the domain. While a sequence runs, `busy_o` is high. `done_o` pulses for one cycle when the sequence finishes. The domain choice (`slave_mode`) and the clock-stop option (`gate_clk`) are sampled when a shutdown request is accepted. They stay in force until the matching restart has finished.

Top module: `dom_cycle_seq`

## Requirements
- R1: While `rst` is high and after it is released, the outputs rest at bypass 0, domain reset 0, clock-enable 1, busy 0, done 0.
- R2: When `shut_req` is sampled high while the domain is running, with `slave_mode`=1, `bypass_o` and `busy_o` rise on that same clock edge. Reset and clock-enable do not change on that edge.
- R3: After the shutdown starts, `dom_rst_o` rises on the first edge that samples `path_idle` high, and no earlier than one edge after the shutdown began. While `path_idle` stays low, the reset stays low.
- R4: With `gate_clk`=1, `dom_clk_en_o` falls exactly HOLD_CYCLES edges after `dom_rst_o` rose. On that edge, `busy_o` falls and `done_o` rises.
- R5: With `gate_clk`=0, `dom_clk_en_o` stays high through the whole shutdown and restart. The shutdown completes HOLD_CYCLES edges after reset rose.
- R6: In a slave-side restart, `dom_clk_en_o` rises (or stays high) and `busy_o` rises on the edge that samples `wake_req`. `dom_rst_o` falls HOLD_CYCLES edges later. `bypass_o` falls one edge after that, together with `done_o`.
- R7: With `slave_mode`=0 (master side), `bypass_o` never rises. The shutdown waits for `path_idle`, then asserts reset. The restart completes on the edge that releases reset.
- R8: These inputs are ignored: `shut_req` while shut down or during a sequence; `wake_req` while running or during a sequence; changes of `slave_mode` or `gate_clk` after a shutdown was accepted.
- R9: Of `bypass_o`, `dom_rst_o` and `dom_clk_en_o`, at most one changes on any clock edge.
- R10: `done_o` is high for exactly one cycle per completed sequence, and `busy_o` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| shut_req | input | 1 | Request to take the target domain out of service |
| wake_req | input | 1 | Request to bring the target domain back |
| path_idle | input | 1 | High when no transaction is in flight in the crossing |
| slave_mode | input | 1 | 1: slave-side handling with bypass; 0: master-side handling |
| gate_clk | input | 1 | 1: stop the domain clock while shut down |
| bypass_o | output | 1 | Makes master requests complete as no-ops |
| dom_rst_o | output | 1 | Reset to the target domain |
| dom_clk_en_o | output | 1 | Clock enable for the target domain |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The hardest case to reach is a drain wait that lasts. Bypass is already high, but the crossing still reports traffic, and a request for the opposite direction arrives in that window. The stimulus holds `path_idle` low for several cycles after the shutdown request and pulses `wake_req` in the middle of that wait. The scoreboard then expects the reset to stay low and the state to stay unchanged until one edge after `path_idle` rises. In the same way, `slave_mode` is flipped during a restart, to show that the value latched at shutdown still decides whether the bypass step runs.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [2:0] {
    ST_ON      = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_HOLD_DN = 3'd2,
    ST_OFF     = 3'd3,
    ST_HOLD_UP = 3'd4,
    ST_BYP_DN  = 3'd5
  } dcs_state_e;
endpackage

// File: rtl/dcs_hold_timer.sv
module dcs_hold_timer #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  localparam int CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == LAST) run <= 1'b0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/dcs_fsm.sv
module dcs_fsm
  import dcs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic shut_req,
  input  logic wake_req,
  input  logic path_idle,
  input  logic slave_mode,
  input  logic gate_clk,
  input  logic hold_expired,
  output logic hold_start,
  output logic bypass_o,
  output logic dom_rst_o,
  output logic dom_clk_en_o,
  output logic busy_o,
  output logic done_o
);
  dcs_state_e st;
  logic       mode_q;
  logic       gate_q;

  // the hold count starts when the domain reset is raised or the clock comes back
  assign hold_start = ((st == ST_DRAIN) && path_idle) ||
                      ((st == ST_OFF) && wake_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_ON;
      mode_q       <= 1'b0;
      gate_q       <= 1'b0;
      bypass_o     <= 1'b0;
      dom_rst_o    <= 1'b0;
      dom_clk_en_o <= 1'b1;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        ST_ON: if (shut_req) begin
          mode_q   <= slave_mode;
          gate_q   <= gate_clk;
          bypass_o <= slave_mode;
          busy_o   <= 1'b1;
          st       <= ST_DRAIN;
        end
        ST_DRAIN: if (path_idle) begin
          dom_rst_o <= 1'b1;
          st        <= ST_HOLD_DN;
        end
        ST_HOLD_DN: if (hold_expired) begin
          if (gate_q) dom_clk_en_o <= 1'b0;
          busy_o <= 1'b0;
          done_o <= 1'b1;
          st     <= ST_OFF;
        end
        ST_OFF: if (wake_req) begin
          dom_clk_en_o <= 1'b1;
          busy_o       <= 1'b1;
          st           <= ST_HOLD_UP;
        end
        ST_HOLD_UP: if (hold_expired) begin
          dom_rst_o <= 1'b0;
          if (mode_q) begin
            st <= ST_BYP_DN;
          end else begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            st     <= ST_ON;
          end
        end
        ST_BYP_DN: begin
          bypass_o <= 1'b0;
          busy_o   <= 1'b0;
          done_o   <= 1'b1;
          st       <= ST_ON;
        end
        default: st <= ST_ON;
      endcase
    end
  end
endmodule

// File: rtl/dom_cycle_seq.sv
module dom_cycle_seq #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic shut_req,
  input  logic wake_req,
  input  logic path_idle,
  input  logic slave_mode,
  input  logic gate_clk,
  output logic bypass_o,
  output logic dom_rst_o,
  output logic dom_clk_en_o,
  output logic busy_o,
  output logic done_o
);
  logic hold_start;
  logic hold_expired;

  dcs_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (hold_start),
    .expired (hold_expired)
  );

  dcs_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .shut_req     (shut_req),
    .wake_req     (wake_req),
    .path_idle    (path_idle),
    .slave_mode   (slave_mode),
    .gate_clk     (gate_clk),
    .hold_expired (hold_expired),
    .hold_start   (hold_start),
    .bypass_o     (bypass_o),
    .dom_rst_o    (dom_rst_o),
    .dom_clk_en_o (dom_clk_en_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker (
  input logic clk,
  input logic rst,
  input logic path_idle,
  input logic bypass_o,
  input logic dom_rst_o,
  input logic dom_clk_en_o,
  input logic busy_o,
  input logic done_o
);
  // R9
  a_r9_single_edge: assert property (@(posedge clk) disable iff (rst)
    $countones({bypass_o != $past(bypass_o), dom_rst_o != $past(dom_rst_o),
                dom_clk_en_o != $past(dom_clk_en_o)}) <= 1);
  // R3
  a_r3_reset_after_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(dom_rst_o) |-> $past(path_idle));
  // R4
  a_r4_gate_under_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(dom_clk_en_o) |-> dom_rst_o && $past(dom_rst_o));
  // R6
  a_r6_release_clocked: assert property (@(posedge clk) disable iff (rst)
    $fell(dom_rst_o) |-> dom_clk_en_o && $past(dom_clk_en_o));
  // R6
  a_r6_bypass_last: assert property (@(posedge clk) disable iff (rst)
    $fell(bypass_o) |-> !dom_rst_o && dom_clk_en_o && done_o);
  // R10
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  // R10
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

bind dom_cycle_seq dcs_checker u_dcs_checker (
  .clk          (clk),
  .rst          (rst),
  .path_idle    (path_idle),
  .bypass_o     (bypass_o),
  .dom_rst_o    (dom_rst_o),
  .dom_clk_en_o (dom_clk_en_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/tb_dom_cycle_seq.sv
module tb_dom_cycle_seq;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shut_req = 1'b0, wake_req = 1'b0, path_idle = 1'b0;
  logic slave_mode = 1'b1, gate_clk = 1'b1;
  logic bypass_o, dom_rst_o, dom_clk_en_o, busy_o, done_o;

  always #4 clk = ~clk; // 125 MHz

  dom_cycle_seq #(.HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst(rst), .shut_req(shut_req), .wake_req(wake_req),
    .path_idle(path_idle), .slave_mode(slave_mode), .gate_clk(gate_clk),
    .bypass_o(bypass_o), .dom_rst_o(dom_rst_o), .dom_clk_en_o(dom_clk_en_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // vector order: {bypass, reset, clk_en, busy, done}
  typedef struct {
    int         at;
    logic [4:0] v;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always @(posedge clk) cyc++;

  task automatic expect_at(int at, logic [4:0] v, string tag);
    exp_t e;
    e.at = at; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  // monitor: compares at falling edges, away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      logic [4:0] act;
      e = q.pop_front();
      act = {bypass_o, dom_rst_o, dom_clk_en_o, busy_o, done_o};
      n_cmp++;
      if (e.at != cyc || act !== e.v) begin
        n_bad++;
        $display("FAIL %s cycle %0d: actual %b expected %b", e.tag, cyc, act, e.v);
      end
    end
  end

  initial begin
    int t;
    step(3);
    expect_at(cyc, 5'b00100, "R1 in reset");
    step(1);
    rst = 1'b0;
    expect_at(cyc + 1, 5'b00100, "R1 after reset");
    step(2);

    // slave-side shutdown with clock stop, long drain
    t = cyc;
    slave_mode = 1'b1; gate_clk = 1'b1; path_idle = 1'b0; shut_req = 1'b1;
    expect_at(t + 1, 5'b10110, "R2 bypass first");
    step(1); shut_req = 1'b0;
    step(1); wake_req = 1'b1;                 // mid-drain wake ignored (R8)
    expect_at(t + 3, 5'b10110, "R8 wake during drain");
    step(1); wake_req = 1'b0; gate_clk = 1'b0; // late option change ignored (R8)
    expect_at(t + 4, 5'b10110, "R3 reset waits for idle");
    step(1); path_idle = 1'b1;
    expect_at(t + 5, 5'b11110, "R3 reset after idle");
    expect_at(t + 4 + HOLD, 5'b11110, "R4 clock on during hold");
    expect_at(t + 5 + HOLD, 5'b11001, "R4 clock gated and done");
    expect_at(t + 6 + HOLD, 5'b11000, "R10 done single cycle");
    step(HOLD + 3);
    t = cyc; shut_req = 1'b1;
    expect_at(t + 1, 5'b11000, "R8 shut while off");
    step(1); shut_req = 1'b0;
    step(2);

    // slave-side restart, mode flipped mid-way
    t = cyc; wake_req = 1'b1;
    expect_at(t + 1, 5'b11110, "R6 clock back first");
    step(1); wake_req = 1'b0;
    step(1); slave_mode = 1'b0;
    expect_at(t + HOLD, 5'b11110, "R6 reset still held");
    expect_at(t + HOLD + 1, 5'b10110, "R6 reset released");
    expect_at(t + HOLD + 2, 5'b00101, "R6 bypass last with done");
    expect_at(t + HOLD + 3, 5'b00100, "R10 back to idle");
    step(HOLD + 4);

    // slave-side shutdown without clock stop
    t = cyc; slave_mode = 1'b1; gate_clk = 1'b0; shut_req = 1'b1;
    expect_at(t + 1, 5'b10110, "R2 bypass rises");
    expect_at(t + 2, 5'b11110, "R3 idle path reset");
    expect_at(t + 2 + HOLD, 5'b11101, "R5 done with clock running");
    step(1); shut_req = 1'b0;
    step(HOLD + 3);
    t = cyc; wake_req = 1'b1;
    expect_at(t + 1, 5'b11110, "R5 restart clock unchanged");
    expect_at(t + HOLD + 1, 5'b10110, "R5 reset released");
    expect_at(t + HOLD + 2, 5'b00101, "R5 bypass drop done");
    step(1); wake_req = 1'b0;
    step(HOLD + 4);

    // master-side cycle with clock stop
    t = cyc; slave_mode = 1'b0; gate_clk = 1'b1; shut_req = 1'b1;
    expect_at(t + 1, 5'b00110, "R7 no bypass");
    expect_at(t + 2, 5'b01110, "R7 reset after idle");
    expect_at(t + 2 + HOLD, 5'b01001, "R7 clock gated done");
    step(1); shut_req = 1'b0;
    step(HOLD + 3);
    t = cyc; wake_req = 1'b1;
    expect_at(t + 1, 5'b01110, "R7 clock back");
    expect_at(t + HOLD + 1, 5'b00101, "R7 done at release");
    expect_at(t + HOLD + 2, 5'b00100, "R10 pulse ends");
    step(1); wake_req = 1'b0;
    step(HOLD + 4);

    // wake while running is ignored
    t = cyc; wake_req = 1'b1;
    expect_at(t + 1, 5'b00100, "R8 wake while on");
    step(1); wake_req = 1'b0;
    step(3);

    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R1 scoreboard: actual %0d pending expected 0", q.size());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule